// File: doc/BRIEF.md
# Up/Down Position Counter with Cascade Output

This block keeps the running position of one encoder axis. A quadrature decoder in front of it supplies a one-clock step request and a direction level. On each clock where a step is requested, the block adds or subtracts one from a 32-bit position register. The register wraps modulo 2^32 in both directions.

When a step carries the count past all ones going up, or past zero going down, the block raises a one-clock cascade pulse. An external counter can use the rising edge of that pulse to extend the range. A direction output travels with the pulse. It reaches its new value before the pulse rises and does not change at the edge where the pulse rises, so the external counter can sample it on that edge.

An active-low reset clears the block at once, whatever the clock is doing. The release of reset is synchronized to the clock. The synchronized reset state is also driven out as a clear indication for a downstream readout latch.

Top module: `ucc_position_counter`

## Requirements
- R1: While `arst_n` is low, without waiting for a clock edge, `position` is 0, `carry_pulse` is 0, `dir_out` is 0 and `latch_clear` is 1.
- R2: After `arst_n` rises, step requests at the first two rising clock edges are ignored and requests from the third edge onward are counted. `latch_clear` falls after the second edge.
- R3: A counted step with `step_up` = 1 increases `position` by one, and one with `step_up` = 0 decreases it by one, modulo 2^32. `position` takes the new value at the same edge.
- R4: On a clock where `step_en` is 0, or while `latch_clear` is 1, `position` keeps its value.
- R5: A counted up step from 0xFFFFFFFF gives 0x00000000. `carry_pulse` is then high for exactly the one clock cycle that follows the next rising edge.
- R6: A counted down step from 0x00000000 gives 0xFFFFFFFF, with the same one-cycle `carry_pulse` timing as R5.
- R7: `dir_out` takes the value of `step_up` (1 = up, 0 = down) at the edge of each counted step, except at an edge that is held back as described in R8.
- R8: After a wrapping step, `dir_out` shows the wrap direction from that edge on. It is not changed at the following edge, where `carry_pulse` rises. If a counted step arrives at that held edge, `dir_out` takes that step's direction one edge later.
- R9: `carry_pulse` rises only two edges after a counted step that wrapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Active-low asynchronous reset |
| step_en | input | 1 | Step request from the decoder, one per clock |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| position | output | 32 | Current count value |
| carry_pulse | output | 1 | One-clock pulse after overflow or underflow |
| dir_out | output | 1 | Direction level that accompanies the cascade pulse |
| latch_clear | output | 1 | High while the block is in reset or synchronizing its release |

## Verification
The checker confirms on every cycle that the count moves by exactly plus or minus one only on accepted steps and holds otherwise. It also checks that every wrap is followed two edges later by a cascade pulse, that no pulse appears without a wrap, and that the direction level is steady across each rising edge of the pulse. Only the bench scenarios can show the synchronized reset release and the counts of ignored edges. The same holds for the asynchronous clear in the middle of a cycle and the exact one-cycle pulse width, because the bench keeps wraps apart.

// File: rtl/ucc_pkg.sv
package ucc_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_e;

    // state of the cascade output stage
    typedef struct packed {
        logic      pend;      // a wrap happened at the last edge
        logic      carry;     // cascade pulse
        step_dir_e dir;       // direction shown with the pulse
        step_dir_e last;      // direction of the most recent counted step
    } casc_state_t;

    localparam casc_state_t CASC_RESET = '{pend: 1'b0, carry: 1'b0,
                                          dir: DIR_DOWN, last: DIR_DOWN};

endpackage

// File: rtl/ucc_rst_sync.sv
module ucc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic run
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign run = st_q.chain[STAGES-1];

endmodule

// File: rtl/ucc_count_core.sv
module ucc_count_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             adv,
    input  logic             step_up,
    output logic [WIDTH-1:0] count,
    output logic             wrap
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        at_top, at_bottom;

    always_comb begin
        at_top    = (st_q.cnt == ALL_ONES);
        at_bottom = (st_q.cnt == '0);
        st_d      = st_q;
        wrap      = 1'b0;
        if (adv) begin
            if (step_up) begin
                st_d.cnt = st_q.cnt + ONE;
                wrap     = at_top;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
                wrap     = at_bottom;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/ucc_cascade_stage.sv
module ucc_cascade_stage
    import ucc_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic adv,
    input  logic step_up,
    input  logic wrap,
    output logic carry,
    output logic dir
);
    casc_state_t st_d, st_q;
    step_dir_e   step_dir;

    always_comb begin
        step_dir = step_up ? DIR_UP : DIR_DOWN;
        st_d       = st_q;
        st_d.pend  = wrap;
        st_d.carry = st_q.pend;
        if (adv) st_d.last = step_dir;
        // hold the direction across the edge where the pulse rises
        if (!st_q.pend) begin
            if (adv) st_d.dir = step_dir;
            else     st_d.dir = st_q.last;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= CASC_RESET;
        else         st_q <= st_d;
    end

    assign carry = st_q.carry;
    assign dir   = (st_q.dir == DIR_UP);

endmodule

// File: rtl/ucc_position_counter.sv
module ucc_position_counter #(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             step_en,
    input  logic             step_up,
    output logic [WIDTH-1:0] position,
    output logic             carry_pulse,
    output logic             dir_out,
    output logic             latch_clear
);
    logic run;
    logic adv;
    logic wrap;

    ucc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .run    (run)
    );

    assign adv = step_en & run;

    ucc_count_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .arst_n  (arst_n),
        .adv     (adv),
        .step_up (step_up),
        .count   (position),
        .wrap    (wrap)
    );

    ucc_cascade_stage u_casc (
        .clk     (clk),
        .arst_n  (arst_n),
        .adv     (adv),
        .step_up (step_up),
        .wrap    (wrap),
        .carry   (carry_pulse),
        .dir     (dir_out)
    );

    assign latch_clear = ~run;

endmodule

// File: rtl/ucc_position_counter_chk.sv
module ucc_position_counter_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             arst_n,
    input logic             step_en,
    input logic             step_up,
    input logic [WIDTH-1:0] position,
    input logic             carry_pulse,
    input logic             dir_out,
    input logic             latch_clear
);
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic accepted;
    logic wrap_seen;
    assign accepted  = step_en && !latch_clear;
    assign wrap_seen = accepted && (step_up ? (position == ALL_ONES) : (position == '0));

    // R1
    always @(posedge clk) begin
        if (!arst_n) begin
            a_r1_reset_clear: assert (position == '0 && !carry_pulse && latch_clear);
        end
    end

    a_r3_count_up: assert property (@(posedge clk) disable iff (!arst_n)
        (accepted && step_up) |=> (position - $past(position)) == ONE);

    a_r3_count_down: assert property (@(posedge clk) disable iff (!arst_n)
        (accepted && !step_up) |=> ($past(position) - position) == ONE);

    a_r4_hold: assert property (@(posedge clk) disable iff (!arst_n)
        !accepted |=> $stable(position));

    a_r5_carry_after_overflow: assert property (@(posedge clk) disable iff (!arst_n)
        (accepted && step_up && position == ALL_ONES) |=> ##1 carry_pulse);

    a_r6_carry_after_underflow: assert property (@(posedge clk) disable iff (!arst_n)
        (accepted && !step_up && position == '0) |=> ##1 carry_pulse);

    a_r8_dir_steady_at_rise: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(carry_pulse) |-> $stable(dir_out));

    a_r9_no_spurious_carry: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(carry_pulse) |-> $past(wrap_seen, 2));

endmodule

bind ucc_position_counter ucc_position_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .arst_n      (arst_n),
    .step_en     (step_en),
    .step_up     (step_up),
    .position    (position),
    .carry_pulse (carry_pulse),
    .dir_out     (dir_out),
    .latch_clear (latch_clear)
);

// File: tb/ucc_position_counter_bench.sv
module ucc_position_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MAXV = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        arst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        step_up = 1'b0;
    logic [31:0] position;
    logic        carry_pulse;
    logic        dir_out;
    logic        latch_clear;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    logic [31:0] m_pos;
    logic        m_pend, m_carry, m_dir, m_last, m_prev_wrap;
    int          m_edges;

    always #(CLK_PERIOD/2) clk = ~clk;

    ucc_position_counter u_ucc_position_counter (
        .clk         (clk),
        .arst_n      (arst_n),
        .step_en     (step_en),
        .step_up     (step_up),
        .position    (position),
        .carry_pulse (carry_pulse),
        .dir_out     (dir_out),
        .latch_clear (latch_clear)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pos = '0; m_pend = 0; m_carry = 0; m_dir = 0; m_last = 0;
        m_prev_wrap = 0; m_edges = 0;
    endtask

    // drive at a falling edge, let one rising edge pass, compare at the next falling edge
    task automatic cyc(input bit en, input bit up);
        bit run_now, adv, wrap;
        step_en = en;
        step_up = up;
        run_now = (m_edges >= 2);
        adv  = en && run_now;
        wrap = adv && (up ? (m_pos == MAXV) : (m_pos == '0));
        @(negedge clk);
        m_carry = m_pend;
        if (!m_pend) m_dir = adv ? up : m_last;
        if (adv) m_last = up;
        m_pend = wrap;
        m_prev_wrap = wrap;
        if (adv) m_pos = up ? m_pos + 1 : m_pos - 1;
        if (m_edges < 2) m_edges++;
        chk(position == m_pos, adv ? "R3 step" : "R4 hold", position, m_pos);
        chk(carry_pulse == m_carry, "R5/R6/R9 carry", {31'd0, carry_pulse}, {31'd0, m_carry});
        chk(dir_out == m_dir, "R7/R8 dir", {31'd0, dir_out}, {31'd0, m_dir});
        chk(latch_clear == (m_edges < 2), "R2 latch_clear", {31'd0, latch_clear}, {31'd0, m_edges < 2});
    endtask

    initial begin
        logic [15:0] lfsr;
        model_reset();
        #(CLK_PERIOD*2 + 1);
        // R1: in reset
        chk(position == 0, "R1 position", position, 0);
        chk(carry_pulse == 0, "R1 carry", {31'd0, carry_pulse}, 0);
        chk(dir_out == 0, "R1 dir", {31'd0, dir_out}, 0);
        chk(latch_clear == 1, "R1 latch_clear", {31'd0, latch_clear}, 1);

        // R2: release at a falling edge with steps requested
        @(negedge clk);
        arst_n = 1'b1;
        cyc(1, 1);
        chk(position == 0, "R2 first edge ignored", position, 0);
        cyc(1, 1);
        chk(position == 0, "R2 second edge ignored", position, 0);
        cyc(1, 1);
        chk(position == 1, "R2 third edge counts", position, 1);

        // R6: down across zero
        cyc(1, 0);
        cyc(1, 0);
        chk(position == MAXV, "R6 underflow value", position, MAXV);
        chk(carry_pulse == 0 && dir_out == 0, "R6 dir before pulse", {30'd0, carry_pulse, dir_out}, 0);
        cyc(0, 0);
        chk(carry_pulse == 1 && dir_out == 0, "R6 pulse high, R8 dir held", {30'd0, carry_pulse, dir_out}, 32'd2);
        cyc(0, 0);
        chk(carry_pulse == 0, "R6 pulse one cycle", {31'd0, carry_pulse}, 0);

        // R5: up across all ones
        cyc(1, 1);
        chk(position == 0, "R5 overflow value", position, 0);
        chk(dir_out == 1 && carry_pulse == 0, "R5 dir before pulse", {30'd0, carry_pulse, dir_out}, 1);
        cyc(1, 1);
        chk(carry_pulse == 1 && dir_out == 1, "R5 pulse high, R8 dir held", {30'd0, carry_pulse, dir_out}, 32'd3);
        cyc(0, 1);
        chk(carry_pulse == 0, "R5 pulse one cycle", {31'd0, carry_pulse}, 0);

        // R3/R4/R7/R9: pseudo-random walk around zero, wraps kept apart
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            bit en, up;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            en = lfsr[0] | lfsr[3];
            up = lfsr[1] ^ (i[9] ? lfsr[5] & lfsr[6] : lfsr[5] | lfsr[6]);
            if (m_prev_wrap) en = 0;
            cyc(en, up);
        end

        // R1: asynchronous clear between edges
        cyc(1, 1);
        #2;
        arst_n = 1'b0;
        #1;
        chk(position == 0, "R1 async clear", position, 0);
        chk(latch_clear == 1, "R1 async latch_clear", {31'd0, latch_clear}, 1);
        chk(carry_pulse == 0 && dir_out == 0, "R1 async outputs", {30'd0, carry_pulse, dir_out}, 0);
        @(negedge clk);
        model_reset();
        arst_n = 1'b1;
        cyc(1, 0);
        cyc(1, 0);
        cyc(1, 0);
        chk(position == MAXV, "R2 resume after second reset", position, MAXV);
        cyc(0, 0);
        cyc(0, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule